// File: doc/BRIEF.md
# Serial EEPROM Page-Write Target

This block is a synthesizable two-wire serial bus target that stands in for the write path of a serial EEPROM. It holds an 8192-byte array. A bus master can store a single byte or a page of up to 32 bytes in it. The clock and data lines are open-drain. The block samples both lines as plain inputs, always drives its data output low, and pulls the data line by asserting an output-enable. A write-protect input stops data bytes from reaching the array.

A write frame proceeds as follows. The master sends a start condition, a select byte with the direction bit low, and two address bytes. One or more data bytes follow, then a stop condition. The block collects the data bytes in a one-row staging buffer. Only the five low address bits advance from one byte to the next, so the row stays fixed. On a valid stop, the block copies the staged bytes into the array. It does this one buffer slot per system clock, over 32 cycles.

A read path lets the array be checked. The master sets an address with a write header, sends a repeated start, and then sends a select byte with the direction bit high. The block then shifts out bytes from that address for as long as the master acknowledges.

Top module: `eeprom_page_target`

## Requirements
- R1: The select byte is sent MSB first and must be the pattern 1010, then three bits equal to `chipSel[2:0]`, then the direction bit (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released for the rest of the frame and stores nothing.
- R2: The first address byte supplies address bits 12..8 from its five low bits, and its upper three bits are ignored. The second address byte supplies bits 7..0. The block acknowledges both address bytes.
- R3: In a write frame with `wrCtrl` low, the block acknowledges each of 1 to 32 data bytes. After a stop, every byte sent is read back from its address.
- R4: After each data byte, only address bits 4..0 increment and bits 12..5 stay fixed. Bytes sent past the end of a row wrap to the start of the same row. A later byte sent to a wrapped position replaces the earlier byte staged there.
- R5: While `wrCtrl` is high, every data byte gets a NoAck (SDA released in the ninth clock) and the array is not changed. The select byte and address bytes are still acknowledged.
- R6: A start condition that arrives after data bytes but before a stop discards the staged bytes, and the array is not changed.
- R7: A stop that arrives before any complete data byte leaves the array unchanged.
- R8: In a read frame, the block drives bytes MSB first, starting at the current address. After each byte the full 13-bit address increments. A master acknowledge asks for another byte, and a NoAck ends the transfer.
- R9: After reset, and whenever no acknowledge or read bit is due, the block keeps SDA released (`sdaOe` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| sdaOut | output | 1 | Data line drive value, always 0 (open drain) |
| sdaOe | output | 1 | High to pull the data line low |
| wrCtrl | input | 1 | Write protect: high blocks data bytes |
| chipSel | input | 3 | Strap value that the select byte must match |

## Verification
The bench targets four failure modes:
- **Row wrap.** A five-byte write that starts two bytes before a row end must land at the row start, not in the next row. A 34-byte write must overwrite slots 0 and 1. A design that carries into bit 5 would corrupt the neighbouring row, and this shows up on readback.
- **Protected and aborted writes.** The bench sends a protected write, a wrong-select frame, a frame aborted by a repeated start, and a frame that stops right after its address. A design that committed on any stop, or ignored `wrCtrl` or the strap pins, would overwrite the known byte at 0x0123.
- **Ignored address bits.** An address byte with its top bits set must still reach the intended location.
- **Sequential reads across a row end.** These must continue into the next row, which catches a read pointer that wraps like the write pointer.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int CE_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_AHI,
    ST_ACK_AHI,
    ST_ALO,
    ST_ACK_ALO,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_TX,
    ST_MACK,
    ST_COMMIT
  } ctlState_e;

  typedef struct packed {
    logic shiftIn;
    logic loadAddrHi;
    logic loadAddrLo;
    logic storeData;
    logic clearPage;
    logic startCommit;
    logic loadTx;
    logic shiftTx;
    logic advanceRead;
  } strobes_t;

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet,
  output logic sdaBit
);

  // [STAGES-1] is the synchronized value, [STAGES] the value one clock older
  logic [STAGES:0] sclPipe;
  logic [STAGES:0] sdaPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-1:0], sdaIn};
    end
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = sclPipe[STAGES-1];
  assign sclOld = sclPipe[STAGES];
  assign sdaNow = sdaPipe[STAGES-1];
  assign sdaOld = sdaPipe[STAGES];

  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;
  assign sdaBit   = sdaNow;

endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl
  import eeprom_wr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclRise,
  input  logic            sclFall,
  input  logic            startDet,
  input  logic            stopDet,
  input  logic            sdaBit,
  input  logic            wrCtrl,
  input  logic [CE_W-1:0] chipSel,
  input  logic [7:0]      rxByte,
  input  logic            txBit,
  input  logic            pageHasData,
  input  logic            commitBusy,
  output strobes_t        strb,
  output ctlState_e       state,
  output logic            sdaOe
);

  ctlState_e stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic ackDrive, ackDriveNxt;
  logic isRead, isReadNxt;
  logic masterAck, masterAckNxt;
  logic devHit;

  assign devHit = (rxByte[7:1] == {DEV_CODE, chipSel});

  always_comb begin
    stateNxt     = state;
    bitCntNxt    = bitCnt;
    ackDriveNxt  = ackDrive;
    isReadNxt    = isRead;
    masterAckNxt = masterAck;
    strb         = '0;

    if (state == ST_COMMIT) begin
      if (!commitBusy) stateNxt = ST_IDLE;
    end else if (startDet) begin
      stateNxt        = ST_DEV;
      bitCntNxt       = '0;
      ackDriveNxt     = 1'b0;
      strb.clearPage  = 1'b1;
    end else if (stopDet) begin
      bitCntNxt   = '0;
      ackDriveNxt = 1'b0;
      if ((state == ST_WDATA || state == ST_ACK_WDATA) && pageHasData) begin
        stateNxt         = ST_COMMIT;
        strb.startCommit = 1'b1;
      end else begin
        stateNxt = ST_IDLE;
      end
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            bitCntNxt    = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntNxt = '0;
            case (state)
              ST_DEV: begin
                if (devHit) begin
                  ackDriveNxt = 1'b1;
                  isReadNxt   = rxByte[0];
                  stateNxt    = ST_ACK_DEV;
                end else begin
                  stateNxt = ST_IDLE;
                end
              end
              ST_AHI: begin
                strb.loadAddrHi = 1'b1;
                ackDriveNxt     = 1'b1;
                stateNxt        = ST_ACK_AHI;
              end
              ST_ALO: begin
                strb.loadAddrLo = 1'b1;
                ackDriveNxt     = 1'b1;
                stateNxt        = ST_ACK_ALO;
              end
              default: begin
                if (!wrCtrl) begin
                  strb.storeData = 1'b1;
                  ackDriveNxt    = 1'b1;
                end
                stateNxt = ST_ACK_WDATA;
              end
            endcase
          end
        end
        ST_ACK_DEV: begin
          if (sclFall) begin
            ackDriveNxt = 1'b0;
            if (isRead) begin
              strb.loadTx = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_AHI;
            end
          end
        end
        ST_ACK_AHI: if (sclFall) begin ackDriveNxt = 1'b0; stateNxt = ST_ALO;   end
        ST_ACK_ALO: if (sclFall) begin ackDriveNxt = 1'b0; stateNxt = ST_WDATA; end
        ST_ACK_WDATA: if (sclFall) begin ackDriveNxt = 1'b0; stateNxt = ST_WDATA; end
        ST_TX: begin
          if (sclRise) begin
            bitCntNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              bitCntNxt        = '0;
              strb.advanceRead = 1'b1;
              stateNxt         = ST_MACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            masterAckNxt = ~sdaBit;
          end else if (sclFall) begin
            if (masterAck) begin
              strb.loadTx = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= bitCntNxt;
      ackDrive  <= ackDriveNxt;
      isRead    <= isReadNxt;
      masterAck <= masterAckNxt;
    end
  end

  assign sdaOe = ackDrive | ((state == ST_TX) & ~txBit);

endmodule

// File: rtl/eeprom_page_datapath.sv
module eeprom_page_datapath
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              sdaBit,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic              pageHasData,
  output logic              commitBusy,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int ROW_W    = ADDR_W - PAGE_W;
  localparam int HI_W     = ADDR_W - 8;

  logic [7:0]          rxShift;
  logic [7:0]          txShift;
  logic [ADDR_W-1:0]   addrR;
  logic [7:0]          pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageMask;
  logic [PAGE_W-1:0]   commitIdx;
  logic                busy;
  logic [7:0]          memArr [DEPTH];
  logic [ROW_W-1:0]    rowSel;

  assign rowSel = addrR[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      addrR     <= '0;
      pageMask  <= '0;
      commitIdx <= '0;
      busy      <= 1'b0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};

      if (strb.loadAddrHi) addrR[ADDR_W-1:8] <= rxShift[HI_W-1:0];
      if (strb.loadAddrLo) addrR[7:0] <= rxShift;
      if (strb.storeData) begin
        addrR[PAGE_W-1:0]              <= addrR[PAGE_W-1:0] + 1'b1;
        pageMask[addrR[PAGE_W-1:0]]    <= 1'b1;
      end
      if (strb.advanceRead) addrR <= addrR + 1'b1;

      if (strb.loadTx)       txShift <= memArr[addrR];
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};

      if (strb.clearPage) pageMask <= '0;

      if (strb.startCommit) begin
        busy      <= 1'b1;
        commitIdx <= '0;
      end else if (busy) begin
        commitIdx <= commitIdx + 1'b1;
        if (commitIdx == PAGE_W'(PAGE_LEN - 1)) begin
          busy     <= 1'b0;
          pageMask <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeData) pageBuf[addrR[PAGE_W-1:0]] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (busy && pageMask[commitIdx]) memArr[{rowSel, commitIdx}] <= pageBuf[commitIdx];
  end

  assign rxByte      = rxShift;
  assign txBit       = txShift[7];
  assign pageHasData = |pageMask;
  assign commitBusy  = busy;
  assign curAddr     = addrR;

endmodule

// File: rtl/eeprom_page_target.sv
module eeprom_page_target
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  output logic            sdaOut,
  output logic            sdaOe,
  input  logic            wrCtrl,
  input  logic [CE_W-1:0] chipSel
);

  logic sclRise, sclFall, startDet, stopDet, sdaBit;
  logic [7:0] rxByte;
  logic txBit, pageHasData, commitBusy;
  logic [ADDR_W-1:0] curAddr;
  strobes_t strb;
  ctlState_e ctlState;

  eeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .sdaBit(sdaBit)
  );

  eeprom_page_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .wrCtrl(wrCtrl), .chipSel(chipSel), .rxByte(rxByte), .txBit(txBit),
    .pageHasData(pageHasData), .commitBusy(commitBusy),
    .strb(strb), .state(ctlState), .sdaOe(sdaOe)
  );

  eeprom_page_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txBit(txBit), .pageHasData(pageHasData),
    .commitBusy(commitBusy), .curAddr(curAddr)
  );

  assign sdaOut = 1'b0;

endmodule

// File: rtl/eeprom_page_target_chk.sv
module eeprom_page_target_chk
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              wrCtrl,
  input ctlState_e         state,
  input strobes_t          strb,
  input logic              commitBusy,
  input logic              pageHasData,
  input logic [ADDR_W-1:0] curAddr
);

  assert_release_when_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_COMMIT) |-> !sdaOe);

  assert_data_ack_needs_wc_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && state == ST_ACK_WDATA) |-> $past(!wrCtrl));

  assert_row_fixed_in_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WDATA || state == ST_ACK_WDATA) &&
     ($past(state) == ST_WDATA || $past(state) == ST_ACK_WDATA))
    |-> $stable(curAddr[ADDR_W-1:PAGE_W]));

  assert_commit_follows_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.startCommit |=> commitBusy);

  assert_commit_needs_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.startCommit |-> pageHasData);

endmodule

bind eeprom_page_target eeprom_page_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .wrCtrl(wrCtrl), .state(ctlState),
  .strb(strb), .commitBusy(commitBusy), .pageHasData(pageHasData), .curAddr(curAddr)
);

// File: tb/test_eeprom_page_target.sv
module test_eeprom_page_target;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic mSda = 1'b1;
  logic wrCtrl = 1'b0;
  logic [2:0] chipSel = 3'b101;
  logic sdaOut, sdaOe, sdaBus;

  int testsRun = 0;
  int testsFailed = 0;

  logic [7:0] txData [0:39];
  logic [7:0] rdData [0:39];

  localparam logic [2:0] CE_OK = 3'b101;

  always #10 clk = ~clk;

  assign sdaBus = mSda & ~(sdaOe & ~sdaOut);

  eeprom_page_target i_eeprom_page_target (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .wrCtrl(wrCtrl), .chipSel(chipSel)
  );

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'(s * 13 + i * 29 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; q();
    sclLine = 1'b1; q();
    mSda = 1'b0; q();
    sclLine = 1'b0; q();
  endtask

  task automatic busStop();
    mSda = 1'b0; q();
    sclLine = 1'b1; q();
    mSda = 1'b1; q();
    repeat (12) q();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; q();
      sclLine = 1'b1; q(); q();
      sclLine = 1'b0;
    end
    q();
    mSda = 1'b1; q();
    sclLine = 1'b1; q();
    ack = (sdaBus == 1'b0);
    q();
    sclLine = 1'b0; q();
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      sclLine = 1'b1; q();
      b[i] = sdaBus; q();
      sclLine = 1'b0;
    end
    q();
    mSda = giveAck ? 1'b0 : 1'b1; q();
    sclLine = 1'b1; q(); q();
    sclLine = 1'b0; q();
    mSda = 1'b1;
  endtask

  task automatic doWrite(input logic [2:0] ce, input logic [7:0] ah, input logic [7:0] al,
                         input int n, output bit devAck, output bit adAck, output int dataAcks);
    bit a1, a2, ad;
    busStart();
    sendByte({4'b1010, ce, 1'b0}, devAck);
    sendByte(ah, a1);
    sendByte(al, a2);
    adAck = a1 & a2;
    dataAcks = 0;
    for (int i = 0; i < n; i++) begin
      sendByte(txData[i], ad);
      if (ad) dataAcks++;
    end
    busStop();
  endtask

  task automatic randomRead(input logic [7:0] ah, input logic [7:0] al, input int n);
    bit a;
    busStart();
    sendByte({4'b1010, CE_OK, 1'b0}, a);
    sendByte(ah, a);
    sendByte(al, a);
    busStart();
    sendByte({4'b1010, CE_OK, 1'b1}, a);
    chk(a, "R8 read select ack", int'(a), 1);
    for (int i = 0; i < n; i++) readByte(i != n - 1, rdData[i]);
    busStop();
  endtask

  task automatic t_reset();
    chk(sdaBus === 1'b1 && sdaOe === 1'b0, "R9 released after reset", int'(sdaOe), 0);
  endtask

  task automatic t_byteWrite();
    bit d, a; int n;
    txData[0] = 8'h5A;
    doWrite(CE_OK, 8'h01, 8'h23, 1, d, a, n);
    chk(d, "R1 select ack", int'(d), 1);
    chk(a, "R2 address acks", int'(a), 1);
    chk(n == 1, "R3 single data ack", n, 1);
    randomRead(8'h01, 8'h23, 1);
    chk(rdData[0] === 8'h5A, "R8 byte readback", int'(rdData[0]), 'h5A);
  endtask

  task automatic t_pageWrite();
    bit d, a; int n; int bad;
    for (int i = 0; i < 32; i++) txData[i] = pat(1, i);
    doWrite(CE_OK, 8'h04, 8'h00, 32, d, a, n);
    chk(n == 32, "R3 full page acks", n, 32);
    randomRead(8'h04, 8'h00, 32);
    bad = 0;
    for (int i = 0; i < 32; i++) if (rdData[i] !== pat(1, i)) begin
      bad++;
      chk(1'b0, "R3 page byte", int'(rdData[i]), int'(pat(1, i)));
    end
    chk(bad == 0, "R3 page readback", bad, 0);
  endtask

  task automatic t_rollover();
    bit d, a; int n;
    txData[0] = 8'hC3;
    doWrite(CE_OK, 8'h0A, 8'h20, 1, d, a, n);
    for (int i = 0; i < 5; i++) txData[i] = pat(2, i);
    doWrite(CE_OK, 8'h0A, 8'h1E, 5, d, a, n);
    chk(n == 5, "R4 wrap acks", n, 5);
    randomRead(8'h0A, 8'h1E, 3);
    chk(rdData[0] === pat(2, 0), "R4 row end slot 30", int'(rdData[0]), int'(pat(2, 0)));
    chk(rdData[1] === pat(2, 1), "R4 row end slot 31", int'(rdData[1]), int'(pat(2, 1)));
    chk(rdData[2] === 8'hC3, "R8 read crosses row, R4 next row kept", int'(rdData[2]), 'hC3);
    randomRead(8'h0A, 8'h00, 3);
    for (int i = 0; i < 3; i++)
      chk(rdData[i] === pat(2, i + 2), "R4 wrapped to row start", int'(rdData[i]), int'(pat(2, i + 2)));
    for (int i = 0; i < 34; i++) txData[i] = pat(3, i);
    doWrite(CE_OK, 8'h0C, 8'h00, 34, d, a, n);
    chk(n == 34, "R4 overlong page acks", n, 34);
    randomRead(8'h0C, 8'h00, 3);
    chk(rdData[0] === pat(3, 32), "R4 slot 0 overwritten", int'(rdData[0]), int'(pat(3, 32)));
    chk(rdData[1] === pat(3, 33), "R4 slot 1 overwritten", int'(rdData[1]), int'(pat(3, 33)));
    chk(rdData[2] === pat(3, 2), "R4 slot 2 kept", int'(rdData[2]), int'(pat(3, 2)));
  endtask

  task automatic t_wcHigh();
    bit d, a; int n;
    wrCtrl = 1'b1;
    txData[0] = 8'hFF; txData[1] = 8'h00;
    doWrite(CE_OK, 8'h01, 8'h23, 2, d, a, n);
    wrCtrl = 1'b0;
    chk(d && a, "R5 header still acked", int'(d && a), 1);
    chk(n == 0, "R5 data NoAck", n, 0);
    randomRead(8'h01, 8'h23, 1);
    chk(rdData[0] === 8'h5A, "R5 memory unchanged", int'(rdData[0]), 'h5A);
  endtask

  task automatic t_ceMismatch();
    bit d, a; int n;
    txData[0] = 8'h99;
    doWrite(3'b100, 8'h01, 8'h23, 1, d, a, n);
    chk(!d, "R1 mismatch NoAck", int'(d), 0);
    chk(n == 0 && !a, "R1 rest of frame ignored", n, 0);
    randomRead(8'h01, 8'h23, 1);
    chk(rdData[0] === 8'h5A, "R1 mismatch no write", int'(rdData[0]), 'h5A);
  endtask

  task automatic t_abort();
    bit a;
    busStart();
    sendByte({4'b1010, CE_OK, 1'b0}, a);
    sendByte(8'h01, a);
    sendByte(8'h23, a);
    sendByte(8'h11, a);
    busStart();
    busStop();
    randomRead(8'h01, 8'h23, 1);
    chk(rdData[0] === 8'h5A, "R6 start aborts write", int'(rdData[0]), 'h5A);
  endtask

  task automatic t_stopNoData();
    bit a;
    busStart();
    sendByte({4'b1010, CE_OK, 1'b0}, a);
    sendByte(8'h01, a);
    sendByte(8'h23, a);
    busStop();
    randomRead(8'h01, 8'h23, 1);
    chk(rdData[0] === 8'h5A, "R7 stop without data", int'(rdData[0]), 'h5A);
  endtask

  task automatic t_upperIgnored();
    bit d, a; int n;
    txData[0] = 8'h77;
    doWrite(CE_OK, 8'hE1, 8'h23, 1, d, a, n);
    chk(a, "R2 address acks with high bits set", int'(a), 1);
    randomRead(8'h01, 8'h23, 1);
    chk(rdData[0] === 8'h77, "R2 upper address bits ignored", int'(rdData[0]), 'h77);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
    $finish;
  end

  initial begin : main
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_byteWrite();
    t_pageWrite();
    t_rollover();
    t_wcHigh();
    t_ceMismatch();
    t_abort();
    t_stopNoData();
    t_upperIgnored();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule